// File: doc/BRIEF.md
# DMA channel transfer sequencer

This block is one DMA channel. It moves a programmed number of operands between a memory address and a device address. Software sets the channel up through a small register port: an operation word (direction, operand size, request mode, address stepping, function codes), an operand count, two start addresses and a pair of interrupt vectors. It then writes a command word to start, pause or abort the channel.

While the channel is running it raises one bus request per operand. The request carries both addresses, the size, the direction and the two 3-bit function codes. The bus finishes the operand with a one-cycle acknowledge. After each acknowledge the count goes down by one and each address counter holds, increments or decrements by the operand width. When the count reaches zero the channel goes idle and sets a done flag. If the channel is aborted, or started with a zero count, it sets an error flag and an error code instead. Either flag drives a maskable interrupt line, and the vector output shows the completion vector or the error vector.

Four request modes decide when the next operand may be issued: rate-limited automatic, full-speed automatic, external request only, and a hybrid mode in which the first operand is automatic and each later one waits for the external request.

Top module: `dma_chan_seq`

## Requirements
- R1: After reset, `xfer_valid` and `irq` are 0 and the status register (index 2) reads 0.
- R2: A write to the command register (index 1) with bit 0 set, made while the channel is idle and the count (index 3) is nonzero, makes the channel active. Status bit 2 then reads 1, and the channel issues the programmed number of operands.
- R3: Register index 0 holds the operation word. Bits [2:1] give the size: 00 byte, 01 word, 10 longword, 11 byte on an 8-bit port. Bits [6:5] give the memory step and bits [8:7] the device step: 00 hold, 01 increment, 10 decrement. After each acknowledged operand, each address counter moves by 1, 2, 4 or 1 (following the size codes in that order) in the direction its step field selects. Both counters read back at index 4 (memory) and index 5 (device).
- R4: Every request presents the current memory and device addresses, the size field, and the direction from operation bit 0 on `xfer_to_mem` (0: memory to device, 1: device to memory). It also presents the memory function code from operation bits [11:9] and the device function code from bits [14:12].
- R5: A request stays asserted with stable addresses until `xfer_ack`. Each acknowledge lowers the count by exactly one.
- R6: When the last operand is acknowledged, the channel goes idle and status bit 0 (done) is set. With the interrupt mask clear, `irq` rises and `irq_vector` shows bits [7:0] of register index 6. Writing 1 to status bit 0 clears done, and `irq` then falls.
- R7: With command bit 4 (interrupt mask) at 1, `irq` stays 0 even though the status flags are set.
- R8: Operation bits [4:3] select the request mode. In mode 01 (full speed) there is one idle cycle between requests. In mode 00 (rate-limited) there are GAP_CYCLES+1 idle cycles between requests.
- R9: In mode 10 no request is issued while `req_in` is low.
- R10: In mode 11 the first operand is issued without `req_in`, and each later operand waits for `req_in`.
- R11: Command bit 2 (halt) at 1 stops new requests and keeps the count and addresses. Writing the command with bit 2 at 0 lets the remaining operands run to completion.
- R12: A command write with bit 3 set while active (abort) makes the channel idle and drops the request. It sets status bit 1 (error) with code 0x11 in status bits [15:8], and `irq_vector` shows bits [15:8] of register index 6.
- R13: A start with a count of zero issues nothing. It sets the error flag with code 0x02.
- R14: If an abort write and the acknowledge of the final operand are taken in the same cycle, the operand is counted (the count becomes 0 and the addresses step), but the status reports the abort error and done stays 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 4 | Register index for the write |
| wr_data | input | DW | Write data |
| rd_addr | input | 4 | Register index for the read |
| rd_data | output | DW | Read data, registered one cycle after rd_addr |
| req_in | input | 1 | External transfer request |
| xfer_valid | output | 1 | Operand request pending |
| xfer_ack | input | 1 | Bus finished the pending operand |
| xfer_mem_addr | output | AW | Memory address of the operand |
| xfer_dev_addr | output | AW | Device address of the operand |
| xfer_size | output | 2 | Operand size code |
| xfer_to_mem | output | 1 | 1 when data moves from device to memory |
| xfer_mem_fc | output | 3 | Function code of the memory cycle |
| xfer_dev_fc | output | 3 | Function code of the device cycle |
| irq | output | 1 | Interrupt request |
| irq_vector | output | 8 | Vector for the pending interrupt |

## Verification
An abort written through the register port and the acknowledge of the final operand can arrive on the same clock edge. That edge would both complete and cancel the channel. The bench provokes it by watching for the last request at a falling edge, then in that same half-cycle driving the abort write while the bus model raises the acknowledge. Correct behaviour is that the count reads zero and the memory address has stepped, but the status holds the abort code with done clear and the error vector is presented.

// File: rtl/dma_seq_pkg.sv
package dma_seq_pkg;
  typedef enum logic [1:0] {SZ_BYTE = 2'b00, SZ_WORD = 2'b01, SZ_LONG = 2'b10, SZ_PORT8 = 2'b11} size_e;
  typedef enum logic [1:0] {RQ_RATED = 2'b00, RQ_FULL = 2'b01, RQ_EXT = 2'b10, RQ_HYBRID = 2'b11} reqmode_e;
  typedef enum logic [1:0] {STP_HOLD = 2'b00, STP_INC = 2'b01, STP_DEC = 2'b10, STP_RSVD = 2'b11} step_e;
  typedef enum logic [1:0] {PH_IDLE = 2'b00, PH_ARM = 2'b01, PH_BUS = 2'b10} phase_e;

  localparam logic [3:0] REG_OPW  = 4'd0;
  localparam logic [3:0] REG_CMD  = 4'd1;
  localparam logic [3:0] REG_STAT = 4'd2;
  localparam logic [3:0] REG_CNT  = 4'd3;
  localparam logic [3:0] REG_MEM  = 4'd4;
  localparam logic [3:0] REG_DEV  = 4'd5;
  localparam logic [3:0] REG_VEC  = 4'd6;

  localparam logic [7:0] CODE_ABORT = 8'h11;
  localparam logic [7:0] CODE_ZERO  = 8'h02;

  localparam int OPW_BITS = 15;

  function automatic logic [2:0] size_bytes(input logic [1:0] sz);
    case (sz)
      SZ_WORD: size_bytes = 3'd2;
      SZ_LONG: size_bytes = 3'd4;
      default: size_bytes = 3'd1;
    endcase
  endfunction
endpackage

// File: rtl/dma_addr_ctr.sv
module dma_addr_ctr
  import dma_seq_pkg::*;
#(
  parameter int AW = 24
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          load,
  input  logic [AW-1:0] load_val,
  input  logic          adv,
  input  logic [1:0]    mode,
  input  logic [1:0]    size,
  output logic [AW-1:0] addr
);
  logic [AW-1:0] stride;
  assign stride = AW'(size_bytes(size));

  always_ff @(posedge clk) begin
    if (rst) begin
      addr <= '0;
    end else if (load) begin
      addr <= load_val;
    end else if (adv) begin
      case (mode)
        STP_INC: addr <= addr + stride;
        STP_DEC: addr <= addr - stride;
        default: addr <= addr;
      endcase
    end
  end

  assert_hold_mode_R3: assert property (@(posedge clk) disable iff (rst)
    (adv && !load && (mode == STP_HOLD)) |=> $stable(addr));
endmodule

// File: rtl/dma_req_gen.sv
module dma_req_gen
  import dma_seq_pkg::*;
#(
  parameter int GAP_CYCLES = 4
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       arm,
  input  logic       beat,
  input  logic [1:0] mode,
  input  logic       req_in,
  output logic       permit
);
  localparam int GW = $clog2(GAP_CYCLES + 1);

  logic [GW-1:0] gap_cnt;
  logic          first_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      gap_cnt <= '0;
      first_q <= 1'b0;
    end else begin
      if (arm) begin
        gap_cnt <= '0;
        first_q <= 1'b1;
      end else if (beat) begin
        gap_cnt <= GW'(GAP_CYCLES);
        first_q <= 1'b0;
      end else if (gap_cnt != '0) begin
        gap_cnt <= gap_cnt - GW'(1);
      end
    end
  end

  always_comb begin
    case (mode)
      RQ_RATED:  permit = (gap_cnt == '0);
      RQ_FULL:   permit = 1'b1;
      RQ_EXT:    permit = req_in;
      default:   permit = first_q | req_in;
    endcase
  end

  assert_rated_spacing_R8: assert property (@(posedge clk) disable iff (rst)
    (beat && (mode == RQ_RATED)) |=> !permit);
endmodule

// File: rtl/dma_chan_seq.sv
module dma_chan_seq
  import dma_seq_pkg::*;
#(
  parameter int AW         = 24,
  parameter int DW         = 32,
  parameter int CW         = 32,
  parameter int GAP_CYCLES = 4
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          wr_en,
  input  logic [3:0]    wr_addr,
  input  logic [DW-1:0] wr_data,
  input  logic [3:0]    rd_addr,
  output logic [DW-1:0] rd_data,
  input  logic          req_in,
  output logic          xfer_valid,
  input  logic          xfer_ack,
  output logic [AW-1:0] xfer_mem_addr,
  output logic [AW-1:0] xfer_dev_addr,
  output logic [1:0]    xfer_size,
  output logic          xfer_to_mem,
  output logic [2:0]    xfer_mem_fc,
  output logic [2:0]    xfer_dev_fc,
  output logic          irq,
  output logic [7:0]    irq_vector
);
  localparam int NSIDE = 2;

  phase_e              phase_q, phase_d;
  logic [OPW_BITS-1:0] opw_q;
  logic [CW-1:0]       count_q;
  logic [7:0]          vec_ok_q, vec_err_q, code_q;
  logic                halt_q, cont_q, mask_q, done_q, err_q;
  logic                idle, cmd_wr, stat_wr, start_req, go, zero_start;
  logic                abort_req, beat, last, issue, permit;
  logic [AW-1:0]       ptr   [NSIDE];
  logic                ld    [NSIDE];
  logic [1:0]          smode [NSIDE];

  assign idle       = (phase_q == PH_IDLE);
  assign cmd_wr     = wr_en && (wr_addr == REG_CMD);
  assign stat_wr    = wr_en && (wr_addr == REG_STAT);
  assign start_req  = cmd_wr && wr_data[0] && idle;
  assign go         = start_req && (count_q != '0);
  assign zero_start = start_req && (count_q == '0);
  assign abort_req  = cmd_wr && wr_data[3] && !idle;
  assign beat       = (phase_q == PH_BUS) && xfer_ack;
  assign last       = beat && (count_q == CW'(1));
  assign issue      = (phase_q == PH_ARM) && permit && !halt_q;

  always_comb begin
    phase_d = phase_q;
    if (abort_req) begin
      phase_d = PH_IDLE;
    end else begin
      case (phase_q)
        PH_IDLE: if (go) phase_d = PH_ARM;
        PH_ARM:  if (issue) phase_d = PH_BUS;
        PH_BUS:  if (beat) phase_d = last ? PH_IDLE : PH_ARM;
        default: phase_d = PH_IDLE;
      endcase
    end
  end

  dma_req_gen #(.GAP_CYCLES(GAP_CYCLES)) u_reqgen (
    .clk    (clk),
    .rst    (rst),
    .arm    (go),
    .beat   (beat),
    .mode   (opw_q[4:3]),
    .req_in (req_in),
    .permit (permit)
  );

  assign smode[0] = opw_q[6:5];
  assign smode[1] = opw_q[8:7];
  assign ld[0]    = wr_en && (wr_addr == REG_MEM) && idle;
  assign ld[1]    = wr_en && (wr_addr == REG_DEV) && idle;

  for (genvar s = 0; s < NSIDE; s++) begin : g_side
    dma_addr_ctr #(.AW(AW)) u_ctr (
      .clk      (clk),
      .rst      (rst),
      .load     (ld[s]),
      .load_val (wr_data[AW-1:0]),
      .adv      (beat),
      .mode     (smode[s]),
      .size     (opw_q[2:1]),
      .addr     (ptr[s])
    );
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      phase_q    <= PH_IDLE;
      opw_q      <= '0;
      count_q    <= '0;
      vec_ok_q   <= '0;
      vec_err_q  <= '0;
      code_q     <= '0;
      halt_q     <= 1'b0;
      cont_q     <= 1'b0;
      mask_q     <= 1'b0;
      done_q     <= 1'b0;
      err_q      <= 1'b0;
      irq        <= 1'b0;
      irq_vector <= '0;
    end else begin
      phase_q <= phase_d;
      if (wr_en && (wr_addr == REG_OPW) && idle) opw_q <= wr_data[OPW_BITS-1:0];
      if (wr_en && (wr_addr == REG_VEC)) begin
        vec_ok_q  <= wr_data[7:0];
        vec_err_q <= wr_data[15:8];
      end
      if (cmd_wr) begin
        cont_q <= wr_data[1];
        halt_q <= wr_data[2];
        mask_q <= wr_data[4];
      end
      if (wr_en && (wr_addr == REG_CNT) && idle) count_q <= wr_data[CW-1:0];
      else if (beat) count_q <= count_q - CW'(1);
      if (stat_wr && wr_data[0]) done_q <= 1'b0;
      if (stat_wr && wr_data[1]) begin
        err_q  <= 1'b0;
        code_q <= '0;
      end
      if (go) begin
        done_q <= 1'b0;
        err_q  <= 1'b0;
        code_q <= '0;
      end
      if (zero_start) begin
        done_q <= 1'b0;
        err_q  <= 1'b1;
        code_q <= CODE_ZERO;
      end
      if (abort_req) begin
        err_q  <= 1'b1;
        code_q <= CODE_ABORT;
      end else if (last) begin
        done_q <= 1'b1;
      end
      irq        <= (done_q | err_q) & ~mask_q;
      irq_vector <= err_q ? vec_err_q : vec_ok_q;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      rd_data <= '0;
    end else begin
      case (rd_addr)
        REG_OPW:  rd_data <= DW'(opw_q);
        REG_CMD:  rd_data <= DW'({mask_q, 1'b0, halt_q, cont_q, 1'b0});
        REG_STAT: rd_data <= DW'({code_q, 5'd0, !idle, err_q, done_q});
        REG_CNT:  rd_data <= DW'(count_q);
        REG_MEM:  rd_data <= DW'(ptr[0]);
        REG_DEV:  rd_data <= DW'(ptr[1]);
        REG_VEC:  rd_data <= DW'({vec_err_q, vec_ok_q});
        default:  rd_data <= '0;
      endcase
    end
  end

  assign xfer_valid    = (phase_q == PH_BUS);
  assign xfer_mem_addr = ptr[0];
  assign xfer_dev_addr = ptr[1];
  assign xfer_size     = opw_q[2:1];
  assign xfer_to_mem   = opw_q[0];
  assign xfer_mem_fc   = opw_q[11:9];
  assign xfer_dev_fc   = opw_q[14:12];

  assert_hold_until_ack_R5: assert property (@(posedge clk) disable iff (rst)
    (xfer_valid && !xfer_ack && !abort_req) |=>
      (xfer_valid && $stable(xfer_mem_addr) && $stable(xfer_dev_addr)));
  assert_count_step_R5: assert property (@(posedge clk) disable iff (rst)
    beat |=> (count_q == $past(count_q) - CW'(1)));
  assert_halt_blocks_R11: assert property (@(posedge clk) disable iff (rst)
    (halt_q && !xfer_valid) |=> !xfer_valid);
  assert_ext_needs_req_R9: assert property (@(posedge clk) disable iff (rst)
    ($rose(xfer_valid) && (opw_q[4:3] == RQ_EXT)) |-> $past(req_in));
  assert_mask_quiet_R7: assert property (@(posedge clk) disable iff (rst)
    $past(mask_q) |-> !irq);
  assert_abort_stops_R12: assert property (@(posedge clk) disable iff (rst)
    abort_req |=> (err_q && !xfer_valid && (code_q == CODE_ABORT)));
  assert_zero_start_R13: assert property (@(posedge clk) disable iff (rst)
    zero_start |=> (err_q && idle));
endmodule

// File: tb/tb_dma_chan_seq.sv
module tb_dma_chan_seq;
  localparam int AW  = 24;
  localparam int DW  = 32;
  localparam int GAP = 4;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          wr_en = 1'b0;
  logic [3:0]    wr_addr = '0;
  logic [DW-1:0] wr_data = '0;
  logic [3:0]    rd_addr = '0;
  logic [DW-1:0] rd_data;
  logic          req_in = 1'b0;
  logic          xfer_valid;
  logic          xfer_ack = 1'b0;
  logic [AW-1:0] xfer_mem_addr, xfer_dev_addr;
  logic [1:0]    xfer_size;
  logic          xfer_to_mem;
  logic [2:0]    xfer_mem_fc, xfer_dev_fc;
  logic          irq;
  logic [7:0]    irq_vector;

  int checks = 0;
  int failures = 0;
  int low_run = 0;
  int last_gap = 0;
  bit seen = 1'b0;
  logic [56:0] exp_q[$];

  always #2 clk = ~clk;

  dma_chan_seq #(.AW(AW), .DW(DW), .CW(32), .GAP_CYCLES(GAP)) dut (
    .clk(clk), .rst(rst), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .rd_addr(rd_addr), .rd_data(rd_data), .req_in(req_in), .xfer_valid(xfer_valid),
    .xfer_ack(xfer_ack), .xfer_mem_addr(xfer_mem_addr), .xfer_dev_addr(xfer_dev_addr),
    .xfer_size(xfer_size), .xfer_to_mem(xfer_to_mem), .xfer_mem_fc(xfer_mem_fc),
    .xfer_dev_fc(xfer_dev_fc), .irq(irq), .irq_vector(irq_vector)
  );

  task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // monitor and bus model: compare each request with the scoreboard, acknowledge it
  always @(negedge clk) begin
    if (rst) begin
      xfer_ack = 1'b0;
    end else if (xfer_valid) begin
      if (exp_q.size() == 0) chk("R2 unexpected request", 64'd1, 64'd0);
      else chk("R3 R4 request fields",
               {xfer_mem_addr, xfer_dev_addr, xfer_size, xfer_to_mem, xfer_mem_fc, xfer_dev_fc},
               exp_q.pop_front());
      xfer_ack = 1'b1;
      if (seen && low_run > 0) last_gap = low_run;
      seen = 1'b1;
      low_run = 0;
    end else begin
      xfer_ack = 1'b0;
      low_run++;
    end
  end

  task automatic wr(input logic [3:0] a, input logic [31:0] d);
    @(negedge clk);
    wr_en = 1'b1; wr_addr = a; wr_data = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic rd(input logic [3:0] a, output logic [31:0] d);
    @(negedge clk);
    rd_addr = a;
    @(negedge clk);
    d = rd_data;
  endtask

  task automatic wait_idle();
    logic [31:0] s;
    for (int i = 0; i < 3000; i++) begin
      rd(4'd2, s);
      if (!s[2]) return;
    end
    chk("R6 channel never idle", 64'd1, 64'd0);
  endtask

  function automatic logic [31:0] opw(input int dir, input int sz, input int rq,
                                      input int ms, input int ds, input int mfc, input int dfc);
    return 32'(dir | (sz << 1) | (rq << 3) | (ms << 5) | (ds << 7) | (mfc << 9) | (dfc << 12));
  endfunction

  // driver: program a run and push the expected requests
  task automatic setup_run(input logic [23:0] m0, input logic [23:0] d0, input int n,
                           input int dir, input int sz, input int rq, input int ms, input int ds,
                           input int mfc, input int dfc);
    logic [23:0] m = m0;
    logic [23:0] d = d0;
    int st = (sz == 2) ? 4 : ((sz == 1) ? 2 : 1);
    wr(4'd0, opw(dir, sz, rq, ms, ds, mfc, dfc));
    wr(4'd3, 32'(n));
    wr(4'd4, {8'd0, m0});
    wr(4'd5, {8'd0, d0});
    for (int i = 0; i < n; i++) begin
      exp_q.push_back({m, d, 2'(sz), 1'(dir), 3'(mfc), 3'(dfc)});
      if (ms == 1) m = m + 24'(st); else if (ms == 2) m = m - 24'(st);
      if (ds == 1) d = d + 24'(st); else if (ds == 2) d = d - 24'(st);
    end
    seen = 1'b0;
    last_gap = 0;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    failures++;
    $display("FAIL watchdog expired");
    $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    logic [31:0] v;
    int nv;
    repeat (5) @(negedge clk);
    rst = 1'b0;
    // R1
    rd(4'd2, v); chk("R1 status after reset", v, 0);
    chk("R1 irq after reset", irq, 0);
    chk("R1 valid after reset", xfer_valid, 0);

    wr(4'd6, 32'h5EA5);
    // R2 R3 R4 R8 full speed, word, memory increments, device holds
    setup_run(24'h1000, 24'h200, 3, 0, 1, 1, 1, 0, 5, 1);
    wr(4'd1, 32'h1);
    wait_idle();
    repeat (3) @(negedge clk);
    chk("R2 all operands issued", exp_q.size(), 0);
    rd(4'd3, v); chk("R5 count at end", v, 0);
    rd(4'd4, v); chk("R3 memory increment by 2", v, 32'h1006);
    rd(4'd5, v); chk("R3 device hold", v, 32'h200);
    chk("R8 full speed gap", last_gap, 1);
    rd(4'd2, v); chk("R6 done status", v, 32'h1);
    chk("R6 irq on done", irq, 1);
    chk("R6 completion vector", irq_vector, 8'hA5);
    wr(4'd2, 32'h1);
    repeat (3) @(negedge clk);
    chk("R6 irq after clear", irq, 0);

    // R9 external request, longword, memory decrement, device increment
    setup_run(24'h8000, 24'h40, 2, 1, 2, 2, 2, 1, 6, 2);
    wr(4'd1, 32'h1);
    nv = 0;
    for (int i = 0; i < 20; i++) begin @(negedge clk); if (xfer_valid) nv++; end
    chk("R9 no request without req_in", nv, 0);
    req_in = 1'b1;
    wait_idle();
    req_in = 1'b0;
    chk("R9 operands after req_in", exp_q.size(), 0);
    rd(4'd4, v); chk("R3 memory decrement by 4", v, 32'h7FF8);
    rd(4'd5, v); chk("R3 device increment by 4", v, 32'h48);
    wr(4'd2, 32'h3);

    // R10 hybrid, 8-bit port size steps by 1
    setup_run(24'h500, 24'h600, 3, 0, 3, 3, 1, 1, 1, 7);
    wr(4'd1, 32'h1);
    repeat (20) @(negedge clk);
    rd(4'd3, v); chk("R10 first operand automatic", v, 2);
    chk("R10 later operands wait", exp_q.size(), 2);
    req_in = 1'b1;
    wait_idle();
    req_in = 1'b0;
    rd(4'd4, v); chk("R3 port size step 1", v, 32'h503);
    wr(4'd2, 32'h3);

    // R8 rated mode spacing
    setup_run(24'h10, 24'h20, 3, 0, 0, 0, 1, 1, 1, 1);
    wr(4'd1, 32'h1);
    wait_idle();
    chk("R8 rated gap", last_gap, GAP + 1);
    chk("R8 rated operands", exp_q.size(), 0);
    wr(4'd2, 32'h3);

    // R11 halt while started
    setup_run(24'h900, 24'h0, 2, 0, 0, 1, 1, 0, 2, 2);
    wr(4'd1, 32'h5);
    repeat (15) @(negedge clk);
    rd(4'd3, v); chk("R11 count frozen by halt", v, 2);
    chk("R11 no request while halted", exp_q.size(), 2);
    wr(4'd1, 32'h0);
    wait_idle();
    chk("R11 resumed to end", exp_q.size(), 0);
    rd(4'd2, v); chk("R11 done after resume", v, 32'h1);
    wr(4'd2, 32'h3);

    // R7 interrupt mask
    setup_run(24'hA00, 24'h0, 1, 0, 0, 1, 0, 0, 1, 1);
    wr(4'd1, 32'h11);
    wait_idle();
    repeat (3) @(negedge clk);
    rd(4'd2, v); chk("R7 done set while masked", v, 32'h1);
    chk("R7 irq masked", irq, 0);
    wr(4'd1, 32'h0);
    wr(4'd2, 32'h3);

    // R12 abort while waiting for a request
    setup_run(24'hB00, 24'h0, 4, 0, 0, 2, 1, 0, 1, 1);
    wr(4'd1, 32'h1);
    repeat (3) @(negedge clk);
    wr(4'd1, 32'h8);
    repeat (3) @(negedge clk);
    rd(4'd2, v); chk("R12 abort status", v, 32'h1102);
    chk("R12 irq on abort", irq, 1);
    chk("R12 error vector", irq_vector, 8'h5E);
    rd(4'd3, v); chk("R12 count kept", v, 4);
    exp_q.delete();
    wr(4'd2, 32'h3);

    // R13 zero count start
    wr(4'd3, 32'h0);
    wr(4'd1, 32'h1);
    repeat (5) @(negedge clk);
    rd(4'd2, v); chk("R13 zero count error", v, 32'h0202);
    wr(4'd2, 32'h3);

    // R14 abort and final acknowledge in the same cycle
    setup_run(24'h300, 24'h0, 1, 0, 1, 2, 1, 0, 1, 1);
    wr(4'd1, 32'h1);
    req_in = 1'b1;
    for (int i = 0; i < 50; i++) begin
      @(negedge clk);
      if (xfer_valid) break;
    end
    wr_en = 1'b1; wr_addr = 4'd1; wr_data = 32'h8;
    @(negedge clk);
    wr_en = 1'b0;
    req_in = 1'b0;
    repeat (3) @(negedge clk);
    rd(4'd2, v); chk("R14 abort wins over done", v, 32'h1102);
    rd(4'd3, v); chk("R14 final operand counted", v, 0);
    rd(4'd4, v); chk("R14 address stepped", v, 32'h302);
    chk("R14 scoreboard drained", exp_q.size(), 0);
    chk("R14 error vector", irq_vector, 8'h5E);

    $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule